// File: doc/BRIEF.md
# Transmit Descriptor Queue Engine

This block moves outgoing frames from memory to a MAC. Software places two-word transmit descriptors in a ring and credits them by writing a count to the enqueue input. For each credited descriptor the engine reads the descriptor, reads the frame buffer one 32-bit word at a time, and streams the bytes to the MAC. Bytes leave each word in little-endian order. When the MAC reports the outcome of a frame, the engine writes a one-word completion status into a status ring and raises a transmit event. Clearing the event is a read-to-clear action, modelled here as a pulse on `int_rd`.

A frame may span several descriptors. Only the descriptor with end-of-frame set produces a status entry, and that entry carries the buffer index from that descriptor. A descriptor with its abort bit set is not sent. The engine writes a status for it that marks the frame as aborted. The status ring has no credit scheme: the engine writes its slots in order and wraps around.

Every data path uses valid/ready handshakes. A transfer happens on a cycle where both valid and ready are high. Once the engine raises `rd_req_valid`, `tx_valid` or `wr_valid`, it keeps that valid high and its payload unchanged until the transfer happens. The engine keeps at most one read outstanding. It expects exactly one `rd_rsp_valid` pulse for each accepted read and has no ready input for responses. The MAC side is a byte sink: `tx_ready` may be low for any number of cycles. `mac_done` is a single-cycle pulse, and the outcome flags are valid in that cycle.

Top module: `txq_engine`

## Requirements
- R1: Descriptor layout and address. Descriptor i occupies two words at `desc_base + 8*i`: word 0 is the byte address of the buffer, and word 1 is the control word. In the control word, bit 31 is end-of-frame, bits 30:16 are the buffer index, bit 15 is abort and bits 11:0 are the byte length. The descriptor index starts at 0 after reset.
- R2: A descriptor that is sent delivers exactly its length in bytes. Byte k comes from buffer word k/4, byte lane k%4 (lane 0 is bits 7:0). `tx_last` is high only on the final byte of an end-of-frame descriptor.
- R3: Enqueue credits. When `enq_valid` is high, `enq_count` is added to the pending count, so a count of 0 changes nothing. A descriptor fetch starts only while the pending count is non-zero, and each fetch takes one credit. With no credit left, the engine stays idle and issues no read.
- R4: Status word of a sent frame. Bit 31 is always 1. Bit 30 copies `mac_ok`, bit 28 copies `mac_no_carrier`, bit 26 copies `mac_late_col`, bit 25 copies `mac_underrun` and bit 24 copies `mac_excess_col`. Bits 20:16 hold `mac_ncol`, and bits 14:0 echo the buffer index of the end-of-frame descriptor. All other bits are 0.
- R5: A descriptor with abort set sends no bytes and does not wait for `mac_done`. Its status word is 0xA0000000 ORed with its buffer index: bit 31 and bit 29 are set, and bit 30 is clear.
- R6: In a frame of several descriptors, the bytes of all descriptors are sent back to back. Exactly one status word is written, carrying the index of the last descriptor.
- R7: Both rings hold RING_ENTRIES entries (default 8) and wrap to 0 after the last one. Status number n goes to `stat_base + 4*(n % RING_ENTRIES)`.
- R8: A new descriptor fetch starts only while both `dma_en` and `tx_en` are high. Credits given while either enable is low are kept.
- R9: `tx_event` is set in the cycle after a status write is accepted. A pulse on `int_rd` clears it, except that a status write in the same cycle wins. `tx_irq` equals `tx_event` ANDed with `irq_en`.
- R10: While `rd_req_valid`, `tx_valid` or `wr_valid` is high and its ready is low, the valid stays high and the payload stays stable in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | Bus-master transmit enable |
| tx_en | input | 1 | Transmit-control enable |
| desc_base | input | 32 | Byte address of descriptor ring slot 0 |
| stat_base | input | 32 | Byte address of status ring slot 0 |
| enq_valid | input | 1 | Enqueue write strobe |
| enq_count | input | PEND_W | Number of descriptors credited |
| irq_en | input | 1 | Interrupt enable for the transmit event |
| int_rd | input | 1 | Read-to-clear pulse for the transmit event |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory read request accepted |
| rd_req_addr | output | 32 | Word-aligned read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data |
| tx_valid | output | 1 | Byte to MAC valid |
| tx_ready | input | 1 | MAC accepts byte |
| tx_data | output | 8 | Byte to MAC |
| tx_last | output | 1 | Final byte of a frame |
| mac_done | input | 1 | MAC frame outcome pulse |
| mac_ok | input | 1 | Frame sent without error |
| mac_no_carrier | input | 1 | Carrier sense was lost |
| mac_late_col | input | 1 | Collision outside the window |
| mac_underrun | input | 1 | Transmit underrun |
| mac_excess_col | input | 1 | Too many collisions |
| mac_ncol | input | 5 | Collision count |
| wr_valid | output | 1 | Status write valid |
| wr_ready | input | 1 | Status write accepted |
| wr_addr | output | 32 | Status slot byte address |
| wr_data | output | 32 | Status word |
| tx_event | output | 1 | Pending transmit event |
| tx_irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the environment never credits more descriptors than the pending counter can hold. They also assume that every length of a non-abort descriptor is non-zero, that buffer addresses are word aligned, that each accepted read returns exactly one response, and that `mac_done` comes only after a byte with `tx_last` set. The bench keeps within these limits. It writes lengths of 1 to 60 bytes into aligned 64-byte buffer slots, answers each read one cycle after it is accepted, and pulses `mac_done` a few cycles after the final byte. It credits at most three descriptors at a time. Ready stalls on the read, byte and status channels follow fixed cycle patterns, so the hold rules get exercised without breaking these assumptions.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_D0_REQ,
    S_D0_WAIT,
    S_D1_REQ,
    S_D1_WAIT,
    S_B_REQ,
    S_B_WAIT,
    S_SEND,
    S_MAC,
    S_STAT
  } txq_state_e;

  // control word field positions (decoded by software and engine alike)
  localparam int unsigned CW_EOF   = 31;
  localparam int unsigned CW_IX_LO = 16;
  localparam int unsigned CW_ABORT = 15;
  localparam int unsigned IX_W     = 15;
  localparam int unsigned LEN_W    = 12;
  localparam int unsigned NCOL_W   = 5;

  typedef struct packed {
    logic              ok;
    logic              no_carrier;
    logic              late_col;
    logic              underrun;
    logic              excess_col;
    logic [NCOL_W-1:0] ncol;
  } mac_res_t;

  function automatic logic [31:0] pack_status(input logic aborted,
                                              input mac_res_t r,
                                              input logic [IX_W-1:0] ix);
    logic [31:0] w;
    w        = '0;
    w[31]    = 1'b1;
    w[29]    = aborted;
    if (!aborted) begin
      w[30]    = r.ok;
      w[28]    = r.no_carrier;
      w[26]    = r.late_col;
      w[25]    = r.underrun;
      w[24]    = r.excess_col;
      w[20:16] = r.ncol;
    end
    w[14:0]  = ix;
    return w;
  endfunction

endpackage

// File: rtl/txq_credit.sv
module txq_credit #(
  parameter int unsigned PEND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic [PEND_W-1:0] enq_count,
  input  logic              take,
  output logic              pend_nz
);

  logic [PEND_W-1:0] count;
  logic [PEND_W:0]   sum;

  always_comb begin
    sum = {1'b0, count};
    if (enq_valid) sum = sum + {1'b0, enq_count};
    if (take)      sum = sum - {{PEND_W{1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= sum[PEND_W-1:0];
  end

  assign pend_nz = (count != '0);

  // R3: credits never wrap past the counter width
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enq_valid |-> !sum[PEND_W]);

  // R3: a fetch only ever consumes an existing credit
  p_take_has_credit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> count != '0);

  // R3: with no enqueue, a fetch removes exactly one credit
  p_take_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !enq_valid) |=> count == $past(count) - 1'b1);

endmodule

// File: rtl/txq_ring_ptr.sv
module txq_ring_ptr #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PTR_W-1:0] idx
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   idx <= '0;
    else if (adv) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  // R7: pointer stays inside the ring
  p_in_ring_r7: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= LAST);

endmodule

// File: rtl/txq_irq.sv
module txq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic pend,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend <= 1'b0;
    else if (set) pend <= 1'b1;
    else if (clr) pend <= 1'b0;
  end

  assign irq = pend & en;

  p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> pend);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !pend);

endmodule

// File: rtl/txq_fetch.sv
module txq_fetch
  import txq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              pend_nz,
  output logic              take,
  input  logic [PTR_W-1:0]  d_idx,
  output logic              d_adv,
  input  logic [PTR_W-1:0]  s_idx,
  output logic              s_adv,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [ADDR_W-1:0] stat_base,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              mac_done,
  input  mac_res_t          mac_res,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data
);

  txq_state_e        st;
  logic [ADDR_W-1:0] baddr;
  logic              eof;
  logic [IX_W-1:0]   ix;
  logic [LEN_W-1:0]  remain;
  logic [31:0]       word;
  logic [1:0]        lane;
  logic [31:0]       status_q;
  logic              unused_bits;

  assign unused_bits = ^rd_rsp_data[14:12];

  logic [ADDR_W-1:0] d_addr;
  assign d_addr = desc_base + (ADDR_W'(d_idx) << 3);

  always_comb begin
    rd_req_valid = 1'b0;
    rd_req_addr  = baddr;
    unique case (st)
      S_D0_REQ: begin rd_req_valid = 1'b1; rd_req_addr = d_addr; end
      S_D1_REQ: begin rd_req_valid = 1'b1; rd_req_addr = d_addr + ADDR_W'(4); end
      S_B_REQ:  rd_req_valid = 1'b1;
      default:  ;
    endcase
  end

  assign take     = (st == S_IDLE) && run && pend_nz;
  assign tx_valid = (st == S_SEND);
  assign tx_data  = word[8*lane +: 8];
  assign tx_last  = eof && (remain == LEN_W'(1));
  assign wr_valid = (st == S_STAT);
  assign wr_addr  = stat_base + (ADDR_W'(s_idx) << 2);
  assign wr_data  = status_q;
  assign s_adv    = wr_valid && wr_ready;
  assign d_adv    = s_adv ||
                    (tx_valid && tx_ready && (remain == LEN_W'(1)) && !eof);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      baddr    <= '0;
      eof      <= 1'b0;
      ix       <= '0;
      remain   <= '0;
      word     <= '0;
      lane     <= '0;
      status_q <= '0;
    end else begin
      unique case (st)
        S_IDLE:    if (take) st <= S_D0_REQ;
        S_D0_REQ:  if (rd_req_ready) st <= S_D0_WAIT;
        S_D0_WAIT: if (rd_rsp_valid) begin
          baddr <= rd_rsp_data[ADDR_W-1:0];
          st    <= S_D1_REQ;
        end
        S_D1_REQ:  if (rd_req_ready) st <= S_D1_WAIT;
        S_D1_WAIT: if (rd_rsp_valid) begin
          eof    <= rd_rsp_data[CW_EOF];
          ix     <= rd_rsp_data[CW_IX_LO +: IX_W];
          remain <= rd_rsp_data[LEN_W-1:0];
          lane   <= '0;
          if (rd_rsp_data[CW_ABORT]) begin
            status_q <= pack_status(1'b1, '0, rd_rsp_data[CW_IX_LO +: IX_W]);
            st       <= S_STAT;
          end else begin
            st <= S_B_REQ;
          end
        end
        S_B_REQ:   if (rd_req_ready) st <= S_B_WAIT;
        S_B_WAIT:  if (rd_rsp_valid) begin
          word <= rd_rsp_data;
          st   <= S_SEND;
        end
        S_SEND:    if (tx_ready) begin
          remain <= remain - 1'b1;
          lane   <= lane + 1'b1;
          if (remain == LEN_W'(1)) begin
            st <= eof ? S_MAC : S_IDLE;
          end else if (lane == 2'd3) begin
            baddr <= baddr + ADDR_W'(4);
            st    <= S_B_REQ;
          end
        end
        S_MAC:     if (mac_done) begin
          status_q <= pack_status(1'b0, mac_res, ix);
          st       <= S_STAT;
        end
        S_STAT:    if (wr_ready) st <= S_IDLE;
        default:   st <= S_IDLE;
      endcase
    end
  end

  // R10: stalled byte keeps its value
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  // R10: stalled read request keeps its address
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> rd_req_valid && $stable(rd_req_addr));

  // R10: stalled status write keeps address and data
  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  // R6: the final byte of a frame hands over to the MAC outcome wait
  p_last_waits_mac_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> st == S_MAC);

  // R2: a sent descriptor never has zero length
  p_len_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_D1_WAIT && rd_rsp_valid && !rd_rsp_data[CW_ABORT])
      |-> rd_rsp_data[LEN_W-1:0] != '0);

  // R8: nothing is fetched while the engine is not running
  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !run) |=> st == S_IDLE);

endmodule

// File: rtl/txq_engine.sv
module txq_engine
  import txq_pkg::*;
#(
  parameter int unsigned RING_ENTRIES = 8,
  parameter int unsigned PEND_W       = 8,
  localparam int unsigned ADDR_W      = 32,
  localparam int unsigned PTR_W       = (RING_ENTRIES > 1) ? $clog2(RING_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic              tx_en,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [ADDR_W-1:0] stat_base,
  input  logic              enq_valid,
  input  logic [PEND_W-1:0] enq_count,
  input  logic              irq_en,
  input  logic              int_rd,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              mac_done,
  input  logic              mac_ok,
  input  logic              mac_no_carrier,
  input  logic              mac_late_col,
  input  logic              mac_underrun,
  input  logic              mac_excess_col,
  input  logic [4:0]        mac_ncol,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic              tx_event,
  output logic              tx_irq
);

  logic             pend_nz, take, d_adv, s_adv;
  logic [PTR_W-1:0] d_idx, s_idx;
  mac_res_t         mres;

  assign mres = '{ok: mac_ok, no_carrier: mac_no_carrier, late_col: mac_late_col,
                  underrun: mac_underrun, excess_col: mac_excess_col, ncol: mac_ncol};

  txq_credit #(.PEND_W(PEND_W)) u_credit (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_count(enq_count),
    .take(take), .pend_nz(pend_nz)
  );

  txq_ring_ptr #(.ENTRIES(RING_ENTRIES)) u_dptr (
    .clk(clk), .rst_n(rst_n), .adv(d_adv), .idx(d_idx)
  );

  txq_ring_ptr #(.ENTRIES(RING_ENTRIES)) u_sptr (
    .clk(clk), .rst_n(rst_n), .adv(s_adv), .idx(s_idx)
  );

  txq_fetch #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .run(dma_en & tx_en), .pend_nz(pend_nz), .take(take),
    .d_idx(d_idx), .d_adv(d_adv), .s_idx(s_idx), .s_adv(s_adv),
    .desc_base(desc_base), .stat_base(stat_base),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .mac_done(mac_done), .mac_res(mres),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  txq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set(s_adv), .clr(int_rd), .en(irq_en),
    .pend(tx_event), .irq(tx_irq)
  );

  // R4/R5: every status written is marked processed
  p_status_processed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[31]);

  // R5: an aborted entry never reports success
  p_abort_not_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_data[29]) |-> !wr_data[30]);

endmodule

// File: tb/txq_engine_bench.sv
module txq_engine_bench;
  localparam int RING = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        dma_en = 1'b1, tx_en = 1'b1, irq_en = 1'b1, int_rd = 1'b0;
  logic        enq_valid = 1'b0;
  logic [7:0]  enq_count = '0;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [31:0] rd_req_addr, rd_rsp_data;
  logic        tx_valid, tx_ready, tx_last;
  logic [7:0]  tx_data;
  logic        mac_done, mac_ok, mac_no_carrier, mac_late_col, mac_underrun, mac_excess_col;
  logic [4:0]  mac_ncol;
  logic        wr_valid, wr_ready, tx_event, tx_irq;
  logic [31:0] wr_addr, wr_data;

  txq_engine u_txq_engine (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .tx_en(tx_en),
    .desc_base(32'h0), .stat_base(32'h100),
    .enq_valid(enq_valid), .enq_count(enq_count), .irq_en(irq_en), .int_rd(int_rd),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .mac_done(mac_done), .mac_ok(mac_ok), .mac_no_carrier(mac_no_carrier),
    .mac_late_col(mac_late_col), .mac_underrun(mac_underrun),
    .mac_excess_col(mac_excess_col), .mac_ncol(mac_ncol),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_event(tx_event), .tx_irq(tx_irq)
  );

  // environment state
  logic [31:0] mem [0:1023];
  logic [31:0] stat_mem [0:RING-1];
  logic [7:0]  cap_b [0:2047];
  logic        cap_l [0:2047];
  logic [9:0]  mac_q [0:63];
  int          nbytes = 0, stat_cnt = 0, rd_cnt = 0, mac_n = 0, mac_wait = 0;
  logic [31:0] last_waddr = '0;
  logic [7:0]  cyc = '0;
  logic        stall = 1'b0;

  assign rd_req_ready = !stall || (cyc[1:0] != 2'd1);
  assign tx_ready     = !stall || (cyc[2:0] != 3'd3 && cyc[2:0] != 3'd6);
  assign wr_ready     = !stall || cyc[0];

  initial begin
    rd_rsp_valid = 1'b0; rd_rsp_data = '0; mac_done = 1'b0;
    {mac_ok, mac_no_carrier, mac_late_col, mac_underrun, mac_excess_col, mac_ncol} = '0;
  end

  always @(posedge clk) begin
    cyc          <= cyc + 1'b1;
    rd_rsp_valid <= 1'b0;
    mac_done     <= 1'b0;
    if (rd_req_valid && rd_req_ready) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= mem[rd_req_addr[11:2]];
      rd_cnt       <= rd_cnt + 1;
    end
    if (tx_valid && tx_ready) begin
      cap_b[nbytes] <= tx_data;
      cap_l[nbytes] <= tx_last;
      nbytes        <= nbytes + 1;
      if (tx_last) mac_wait <= 4;
    end else if (mac_wait != 0) begin
      mac_wait <= mac_wait - 1;
      if (mac_wait == 1) begin
        mac_done <= 1'b1;
        {mac_ok, mac_no_carrier, mac_late_col, mac_underrun, mac_excess_col, mac_ncol} <= mac_q[mac_n];
        mac_n <= mac_n + 1;
      end
    end
    if (wr_valid && wr_ready) begin
      stat_mem[wr_addr[4:2]] <= wr_data;
      last_waddr             <= wr_addr;
      stat_cnt               <= stat_cnt + 1;
    end
  end

  // expectations
  int          errors = 0, checks = 0;
  int          bd = 0, nf = 0, exp_n = 0, mac_pn = 0;
  logic [7:0]  exp_b [0:2047];
  logic        exp_l [0:2047];
  logic [31:0] exp_stat [0:63];
  int          exp_start [0:63];
  int          exp_end [0:63];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int f, input int j, input int k);
    return 8'((f * 37 + j * 11 + k * 3 + 5) & 255);
  endfunction

  task automatic prep(input int f, input int nd, input int l0, input int l1, input int l2, input bit ab);
    int lens[3];
    logic [14:0] ix;
    logic ok, nocrs, late, under, excess;
    logic [4:0] ncol;
    lens = '{l0, l1, l2};
    ix = '0;
    exp_start[nf] = exp_n;
    for (int j = 0; j < nd; j++) begin
      ix = 15'(32'h1200 + f * 3 + j);
      mem[bd * 2]     = 32'h200 + 32'(bd * 64);
      mem[bd * 2 + 1] = {j == nd - 1, ix, ab, 3'b000, 12'(lens[j])};
      if (!ab) begin
        for (int k = 0; k < lens[j]; k++) begin
          mem[128 + bd * 16 + k / 4][8 * (k % 4) +: 8] = bval(f, j, k);
          exp_b[exp_n] = bval(f, j, k);
          exp_l[exp_n] = (j == nd - 1) && (k == lens[j] - 1);
          exp_n++;
        end
      end
      bd = (bd + 1) % RING;
    end
    ok = (f % 3) != 0; nocrs = (f % 5) == 4; late = (f % 4) == 1;
    under = (f % 6) == 5; excess = (f % 7) == 3; ncol = 5'((f * 7) % 32);
    if (ab) exp_stat[nf] = 32'hA000_0000 | {17'b0, ix};
    else begin
      exp_stat[nf] = {1'b1, ok, 1'b0, nocrs, 1'b0, late, under, excess, 3'b000, ncol, 1'b0, ix};
      mac_q[mac_pn] = {ok, nocrs, late, under, excess, ncol};
      mac_pn++;
    end
    exp_end[nf] = exp_n;
    nf++;
  endtask

  task automatic enq(input int n);
    @(negedge clk); enq_valid = 1'b1; enq_count = 8'(n);
    @(negedge clk); enq_valid = 1'b0; enq_count = '0;
  endtask

  task automatic wait_stat(input int k);
    int t = 0;
    while (stat_cnt <= k && t < 4000) begin @(negedge clk); t++; end
  endtask

  // status k: word, slot address, bytes of its frame
  task automatic check_frame(input int k, input string req);
    bit good = 1'b1;
    int bad = 0;
    wait_stat(k);
    chk(stat_cnt == k + 1, {req, " R3 status count"}, 32'(stat_cnt), 32'(k + 1));
    chk(stat_mem[k % RING] == exp_stat[k], {req, " R4 status word"}, stat_mem[k % RING], exp_stat[k]);
    chk(last_waddr == 32'h100 + 32'(4 * (k % RING)), "R7 status slot address",
        last_waddr, 32'h100 + 32'(4 * (k % RING)));
    for (int i = exp_start[k]; i < exp_end[k]; i++)
      if (cap_b[i] !== exp_b[i] || cap_l[i] !== exp_l[i]) begin
        if (good) bad = i;
        good = 1'b0;
      end
    chk(good && nbytes == exp_end[k], {req, " R2 byte stream"},
        {cap_l[bad], 15'(nbytes), cap_b[bad]}, {exp_l[bad], 15'(exp_end[k]), exp_b[bad]});
  endtask

  task automatic clear_irq();
    @(negedge clk); int_rd = 1'b1;
    @(negedge clk); int_rd = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int rd0, nb0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !wr_valid && !rd_req_valid, "R3 reset outputs idle",
        {29'b0, tx_valid, wr_valid, rd_req_valid}, 32'h0);
    chk(!tx_event && !tx_irq, "R9 reset event clear", {30'b0, tx_event, tx_irq}, 32'h0);

    // R8: credit given while transmit enable is low is held
    tx_en = 1'b0;
    prep(100, 1, 5, 0, 0, 1'b0);
    enq(1);
    repeat (60) @(negedge clk);
    chk(rd_cnt == 0 && nbytes == 0, "R8 no fetch with tx_en low", 32'(rd_cnt), 32'h0);
    dma_en = 1'b0; tx_en = 1'b1;
    repeat (60) @(negedge clk);
    chk(rd_cnt == 0 && nbytes == 0, "R8 no fetch with dma_en low", 32'(rd_cnt), 32'h0);
    dma_en = 1'b1;
    check_frame(0, "R8 held credit");
    chk(tx_irq == 1'b1, "R9 irq after status", 32'(tx_irq), 32'h1);
    clear_irq();
    chk(!tx_event && !tx_irq, "R9 read clears event", {30'b0, tx_event, tx_irq}, 32'h0);

    // R2/R4/R7/R10: length sweep, rings wrap, stalls alternate
    for (int f = 1; f <= 12; f++) begin
      stall = f[0];
      irq_en = (f % 4) != 2;
      prep(f, 1, f, 0, 0, 1'b0);
      enq(1);
      check_frame(nf - 1, "R10 sweep");
      chk(tx_irq == irq_en && tx_event, "R9 irq gate",
          {30'b0, tx_event, tx_irq}, {30'b0, 1'b1, irq_en});
      clear_irq();
    end
    irq_en = 1'b1;

    // R6: three-descriptor frame, only one status
    stall = 1'b1;
    prep(20, 3, 3, 5, 2, 1'b0);
    enq(3);
    check_frame(nf - 1, "R6 multi-descriptor");
    repeat (40) @(negedge clk);
    chk(stat_cnt == nf, "R6 single status per frame", 32'(stat_cnt), 32'(nf));

    // R5: aborted descriptor
    nb0 = nbytes;
    prep(21, 1, 9, 0, 0, 1'b1);
    enq(1);
    check_frame(nf - 1, "R5 abort");
    chk(nbytes == nb0, "R5 no bytes on abort", 32'(nbytes), 32'(nb0));
    clear_irq();

    // R3: zero credit does nothing
    rd0 = rd_cnt;
    enq(0);
    repeat (50) @(negedge clk);
    chk(rd_cnt == rd0, "R3 enqueue of zero", 32'(rd_cnt), 32'(rd0));

    // R3: three credits in one write, then the engine stops
    stall = 1'b0;
    prep(30, 1, 7, 0, 0, 1'b0);
    prep(31, 1, 4, 0, 0, 1'b0);
    prep(32, 1, 11, 0, 0, 1'b0);
    enq(3);
    check_frame(nf - 3, "R3 batch first");
    check_frame(nf - 2, "R3 batch second");
    check_frame(nf - 1, "R3 batch third");
    rd0 = rd_cnt;
    repeat (100) @(negedge clk);
    chk(rd_cnt == rd0 && stat_cnt == nf, "R3 stops at zero credit", 32'(rd_cnt), 32'(rd0));

    // R1: descriptor fetch address follows the ring after wrap
    prep(40, 1, 2, 0, 0, 1'b0);
    enq(1);
    check_frame(nf - 1, "R1 descriptor after wrap");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule